// File: doc/BRIEF.md
# Circular Pass-Window Phase Selector

This block picks one sampling phase from the outcome of a phase sweep. The caller presents a map with one bit per candidate phase (a set bit means that phase sampled correctly) together with a one-cycle start strobe. The block walks the map one phase per clock. It groups the passing phases into runs of adjacent values and treats the phase range as a circle, so a run touching the top phase and a run starting at phase 0 can form one window. It then keeps the longest window and returns a phase about three quarters of the way into it.

The outcome is a phase number, an error flag and a one-cycle valid pulse. The phase and error outputs keep their value until the next result replaces them. The sweep itself (driving the delay line and judging each phase) stays outside the block. Only the decision is made here.

Top module: `phase_window_picker`

## Requirements
- R1: A map with no bit set produces `err_o`=1 with the valid pulse. A map with at least one bit set produces `err_o`=0. A run made by joining the two end runs can never reach NPH phases, so it never raises the error.
- R2: Runs are formed in rising phase order. Bit i of `pass_map_i` stands for phase i. A new run begins wherever a passing phase is not exactly one above the previous passing phase.
- R3: The two end runs are joined only when the lowest run starts at phase 0 and a different, later run contains phase NPH-1. The joined run begins at the first phase of the upper run and continues through NPH-1, then 0, then upward. It takes the scan position of the upper run.
- R4: No joining happens when the lowest run does not start at phase 0, or when no separate run reaches phase NPH-1. When every phase passes there is a single run and nothing is joined.
- R5: The longest run wins by strict comparison in scan order, so of runs with equal length the earliest one wins.
- R6: Let L be the length of the winning run and k = floor(3·L/4). Reduce k by one when it is nonzero. The result is the phase k steps after the first phase of the run, modulo NPH.
- R7: With NPH=16 and every phase passing, the result is phase 11.
- R8: `valid_o` is high for exactly one cycle, NPH+2 clock cycles after the edge that samples `start_i`.
- R9: `phase_o` and `err_o` change only together with the valid pulse and hold their value between results. A result without error always names a phase whose map bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle strobe; samples the map and (re)starts a scan |
| pass_map_i | input | NPH | One bit per phase, set = phase passed |
| phase_o | output | $clog2(NPH) | Selected phase |
| valid_o | output | 1 | One-cycle pulse when a new result is presented |
| err_o | output | 1 | Set with the pulse when no phase can be chosen |

## Verification
The bench builds the block with the default NPH=16. At this size the all-pass map yields phase 11, and a joined window can wrap past phase 15 back to low phases. The size also allows three separate runs, so the block must choose among a first run, a middle run and a last run. Directed maps cover joined windows that win, joined windows that lose a tie to an earlier middle run, lone end runs that must not be joined, and short runs of length 1, 2 and 4, where the index reduction matters most.

// File: rtl/phase_window_pkg.sv
// Shared types for the phase window picker.
package phase_window_pkg;
    // Control states of the scanning sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } pick_state_e;
endpackage

// File: rtl/pwp_run_tracker.sv
// Run tracker: follows the run of passing phases that is currently open
// while the map is walked one position per step. It reports a run-end
// event, with the run's first phase and its length, on the step where a
// failing position follows a passing one.
// Assumes: the caller supplies a final virtual failing step after the last
// phase, so every run gets closed.
module pwp_run_tracker #(
    parameter int NPH = 16,
    localparam int PW = $clog2(NPH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    input  logic          hit_i,
    input  logic [PW:0]   pos_i,
    output logic          end_o,
    output logic [PW-1:0] end_start_o,
    output logic [PW:0]   end_len_o
);
    logic          in_run_q;
    logic [PW-1:0] start_q;
    logic [PW:0]   len_q;

    // Open, extend or close the current run on each scan step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            in_run_q <= 1'b0;
            start_q  <= '0;
            len_q    <= '0;
        end else if (step_i) begin
            if (hit_i) begin
                if (in_run_q) begin
                    len_q <= len_q + 1'b1;
                end else begin
                    in_run_q <= 1'b1;
                    start_q  <= pos_i[PW-1:0];
                    len_q    <= {{PW{1'b0}}, 1'b1};
                end
            end else begin
                in_run_q <= 1'b0;
                len_q    <= '0;
            end
        end
    end

    // A run closes on a failing step while a run is open.
    assign end_o       = step_i && !hit_i && in_run_q;
    assign end_start_o = start_q;
    assign end_len_o   = len_q;

    // R2: an open run is never empty and never longer than the phase count.
    p_run_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_run_q |-> (len_q != '0) && (len_q <= NPH[PW:0]));
endmodule

// File: rtl/pwp_run_book.sv
// Run book: keeps the first closed run, the last closed run, and the best
// run seen strictly between them. The best is chosen by strict greater-than
// in scan order, so the earliest run wins a tie.
// Assumes: run-end events arrive in rising phase order.
module pwp_run_book #(
    parameter int NPH = 16,
    localparam int PW = $clog2(NPH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          end_i,
    input  logic [PW-1:0] end_start_i,
    input  logic [PW:0]   end_len_i,
    output logic          first_vld_o,
    output logic [PW-1:0] first_start_o,
    output logic [PW:0]   first_len_o,
    output logic [PW-1:0] mid_start_o,
    output logic [PW:0]   mid_len_o,
    output logic          last_vld_o,
    output logic [PW-1:0] last_start_o,
    output logic [PW:0]   last_len_o
);
    logic          first_vld_q, last_vld_q;
    logic [PW-1:0] first_start_q, mid_start_q, last_start_q;
    logic [PW:0]   first_len_q, mid_len_q, last_len_q;

    // File each closed run as first, or push the held last run into the middle slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            first_vld_q   <= 1'b0;
            last_vld_q    <= 1'b0;
            first_start_q <= '0;
            mid_start_q   <= '0;
            last_start_q  <= '0;
            first_len_q   <= '0;
            mid_len_q     <= '0;
            last_len_q    <= '0;
        end else if (end_i) begin
            if (!first_vld_q) begin
                first_vld_q   <= 1'b1;
                first_start_q <= end_start_i;
                first_len_q   <= end_len_i;
            end else begin
                if (last_vld_q && (last_len_q > mid_len_q)) begin
                    mid_start_q <= last_start_q;
                    mid_len_q   <= last_len_q;
                end
                last_vld_q   <= 1'b1;
                last_start_q <= end_start_i;
                last_len_q   <= end_len_i;
            end
        end
    end

    assign first_vld_o   = first_vld_q;
    assign first_start_o = first_start_q;
    assign first_len_o   = first_len_q;
    assign mid_start_o   = mid_start_q;
    assign mid_len_o     = mid_len_q;
    assign last_vld_o    = last_vld_q;
    assign last_start_o  = last_start_q;
    assign last_len_o    = last_len_q;

    // R2: every later run starts above the first run.
    p_run_order_r2: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
        (end_i && first_vld_q) |-> (end_start_i > first_start_q));
endmodule

// File: rtl/pwp_pick.sv
// Pick unit: decides whether the two end runs are joined across the wrap,
// chooses the winning run, and computes the three-quarter phase as the
// run's first phase plus an index, modulo NPH. The run contents are never
// stored.
// Assumes: NPH is a power of two, so truncating the sum gives the modulo.
module pwp_pick #(
    parameter int NPH = 16,
    localparam int PW = $clog2(NPH),
    localparam int LW = PW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          first_vld_i,
    input  logic [PW-1:0] first_start_i,
    input  logic [PW:0]   first_len_i,
    input  logic [PW-1:0] mid_start_i,
    input  logic [PW:0]   mid_len_i,
    input  logic          last_vld_i,
    input  logic [PW-1:0] last_start_i,
    input  logic [PW:0]   last_len_i,
    output logic [PW-1:0] phase_o,
    output logic          err_o
);
    logic          merge;
    logic [LW-1:0] last_end, joined_len, win_len, idx;
    logic [PW-1:0] win_start;

    // Join the end runs when the first run starts at 0 and a separate last run ends at the top phase.
    always_comb begin
        last_end   = LW'(last_start_i) + LW'(last_len_i);
        joined_len = LW'(first_len_i) + LW'(last_len_i);
        merge      = first_vld_i && last_vld_i && (first_start_i == '0) &&
                     (last_end == LW'(NPH));
    end

    // Choose the winning run by strict comparison in scan order.
    always_comb begin
        if (merge) begin
            if (joined_len > LW'(mid_len_i)) begin
                win_len   = joined_len;
                win_start = last_start_i;
            end else begin
                win_len   = LW'(mid_len_i);
                win_start = mid_start_i;
            end
        end else begin
            win_len   = LW'(first_len_i);
            win_start = first_start_i;
            if (LW'(mid_len_i) > win_len) begin
                win_len   = LW'(mid_len_i);
                win_start = mid_start_i;
            end
            if (last_vld_i && (LW'(last_len_i) > win_len)) begin
                win_len   = LW'(last_len_i);
                win_start = last_start_i;
            end
        end
    end

    // Three-quarter index, less one when nonzero, added to the run start with wrap.
    always_comb begin
        idx = (win_len * LW'(3)) >> 2;
        if (idx != '0) begin
            idx = idx - 1'b1;
        end
        phase_o = win_start + idx[PW-1:0];
        err_o   = !first_vld_i || (merge && (joined_len >= LW'(NPH)));
    end

    // R3: a joined window always leaves at least one failing phase, so it stays below NPH.
    p_join_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        merge |-> (joined_len < LW'(NPH)));
endmodule

// File: rtl/phase_window_picker.sv
// Phase window picker (top): samples the pass map on a start strobe and
// walks it one phase per cycle, plus one virtual failing step. It then
// registers the chosen phase and error flag with a one-cycle valid pulse.
// Assumes: a start strobe during a scan restarts the scan with the new map.
module phase_window_picker
    import phase_window_pkg::*;
#(
    parameter int NPH = 16,
    localparam int PW = $clog2(NPH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [NPH-1:0] pass_map_i,
    output logic [PW-1:0]  phase_o,
    output logic           valid_o,
    output logic           err_o
);
    pick_state_e    state_q;
    logic [NPH-1:0] map_q;
    logic [PW:0]    step_q;
    logic           step_en, hit;

    logic          run_end;
    logic [PW-1:0] run_start;
    logic [PW:0]   run_len;
    logic          first_vld, last_vld;
    logic [PW-1:0] first_start, mid_start, last_start;
    logic [PW:0]   first_len, mid_len, last_len;
    logic [PW-1:0] pick_phase;
    logic          pick_err;

    // Current scan bit; the step past the top phase reads as failing.
    assign step_en = (state_q == ST_SCAN);
    assign hit     = (step_q < NPH[PW:0]) ? map_q[step_q[PW-1:0]] : 1'b0;

    // Sequencer: sample on start, step through the map, then publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            map_q   <= '0;
            step_q  <= '0;
            phase_o <= '0;
            err_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (start_i) begin
                map_q   <= pass_map_i;
                step_q  <= '0;
                state_q <= ST_SCAN;
            end else begin
                case (state_q)
                    ST_SCAN: begin
                        step_q <= step_q + 1'b1;
                        if (step_q == NPH[PW:0]) begin
                            state_q <= ST_DONE;
                        end
                    end
                    ST_DONE: begin
                        phase_o <= pick_phase;
                        err_o   <= pick_err;
                        valid_o <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    pwp_run_tracker #(.NPH(NPH)) tracker_i (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i), .step_i(step_en),
        .hit_i(hit), .pos_i(step_q), .end_o(run_end),
        .end_start_o(run_start), .end_len_o(run_len)
    );

    pwp_run_book #(.NPH(NPH)) book_i (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i), .end_i(run_end),
        .end_start_i(run_start), .end_len_i(run_len),
        .first_vld_o(first_vld), .first_start_o(first_start), .first_len_o(first_len),
        .mid_start_o(mid_start), .mid_len_o(mid_len),
        .last_vld_o(last_vld), .last_start_o(last_start), .last_len_o(last_len)
    );

    pwp_pick #(.NPH(NPH)) pick_i (
        .clk(clk), .rst_n(rst_n),
        .first_vld_i(first_vld), .first_start_i(first_start), .first_len_i(first_len),
        .mid_start_i(mid_start), .mid_len_i(mid_len),
        .last_vld_i(last_vld), .last_start_i(last_start), .last_len_i(last_len),
        .phase_o(pick_phase), .err_o(pick_err)
    );

    // R8: the valid flag is a single-cycle pulse.
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R1: the error flag marks exactly the empty map.
    p_err_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (err_o == (map_q == '0)));

    // R9: a successful result names a passing phase.
    p_pick_passes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !err_o) |-> map_q[phase_o]);

    // R9: outputs hold unless a result is being published.
    p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DONE) |=> ($stable(phase_o) && $stable(err_o)));
endmodule

// File: tb/phase_window_picker_tb.sv
// Directed bench for the phase window picker, one task per scenario.
module phase_window_picker_tb_top;
    localparam int NPH = 16;
    localparam int PW  = $clog2(NPH);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [NPH-1:0] pass_map_i = '0;
    logic [PW-1:0]  phase_o;
    logic           valid_o;
    logic           err_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    phase_window_picker #(.NPH(NPH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pass_map_i(pass_map_i),
        .phase_o(phase_o), .valid_o(valid_o), .err_o(err_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Run one map; checks latency (R8), error flag (R1), phase and pass bit (R9).
    task automatic run_map(input string req, input logic [NPH-1:0] m,
                           input int exp_phase, input bit exp_err);
        int cnt;
        @(negedge clk);
        pass_map_i = m;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 0;
        while (!valid_o && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        if (cnt >= 100) begin
            n_checks++;
            n_fails++;
            $display("FAIL R8 watchdog: actual no valid expected valid");
        end else begin
            chk("R8", "latency", cnt, NPH + 2);
            chk("R1", "err", int'(err_o), int'(exp_err));
            if (!exp_err) begin
                chk(req, "phase", int'(phase_o), exp_phase);
                chk("R9", "selected phase passes", int'(m[phase_o]), 1);
            end
            @(negedge clk);
            chk("R8", "pulse width", int'(valid_o), 0);
        end
    endtask

    task automatic t_reset();
        chk("R8", "reset valid", int'(valid_o), 0);
        chk("R9", "reset err", int'(err_o), 0);
        chk("R9", "reset phase", int'(phase_o), 0);
    endtask

    task automatic t_empty();      run_map("R1", 16'h0000, 0, 1'b1); endtask
    task automatic t_all_pass();   run_map("R7", 16'hFFFF, 11, 1'b0); endtask
    task automatic t_single();     run_map("R6", 16'h0020, 5, 1'b0); endtask
    task automatic t_len2();       run_map("R6", 16'h0180, 7, 1'b0); endtask
    task automatic t_len4();       run_map("R6", 16'h3C00, 12, 1'b0); endtask
    // R2: runs {2..4} and {8..13}; longer wins, 8+3.
    task automatic t_split();      run_map("R2", 16'h3F1C, 11, 1'b0); endtask
    // R3: {0..3} joined after {14,15}: length 6, start 14, index 3 -> wraps to 1.
    task automatic t_wrap();       run_map("R3", 16'hC00F, 1, 1'b0); endtask
    // R3: {0} and {15} joined: length 2, result 15.
    task automatic t_wrap_ends();  run_map("R3", 16'h8001, 15, 1'b0); endtask
    // R4: {1..3} and {15}: no join, first run wins -> 2.
    task automatic t_no_join();    run_map("R4", 16'h800E, 2, 1'b0); endtask
    // R5: equal runs {2..4} and {9..11}: earliest wins -> 3.
    task automatic t_tie();        run_map("R5", 16'h0E1C, 3, 1'b0); endtask
    // R5: joined {14,15,0} ties middle {5..7}: middle earlier -> 6.
    task automatic t_tie_joined(); run_map("R5", 16'hC0E1, 6, 1'b0); endtask

    // R9: outputs hold after the pulse while idle.
    task automatic t_hold();
        logic [PW-1:0] p;
        run_map("R6", 16'h0380, 8, 1'b0);
        p = phase_o;
        repeat (10) @(negedge clk);
        chk("R9", "held phase", int'(phase_o), int'(p));
        chk("R9", "held err", int'(err_o), 0);
        chk("R8", "idle valid", int'(valid_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_all_pass();
        t_single();
        t_len2();
        t_len4();
        t_split();
        t_wrap();
        t_wrap_ends();
        t_no_join();
        t_tie();
        t_tie_joined();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R8 global watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule